// File: doc/BRIEF.md
# Packet Timestamp Capture Unit

This unit freezes the free-running 64-bit system time at the instant a frame crosses the stamping point of the MAC, on the receive side, the transmit side, or both. Each direction owns a single capture slot. A slot is filled only when that direction's enable is set, when the frame qualifies, and when the slot is empty. Once filled, it rejects every further event until software reads its high stamp word. That read empties the slot and re-arms it. Software can therefore always tell which frame a held stamp belongs to.

Software reaches the unit through a plain 32-bit register port. Read data is combinational on the address. Read side effects take place at the clock edge where `reg_rd` is high. On the receive side, a per-frame status output tells the receive datapath, in the cycle of its event pulse, whether that frame was stamped. On the transmit side, a frame qualifies only when its command carries a stamp request.

Top module: `pkt_tstamp_capture`

## Requirements
- R1: After reset both enables are 0, the receive type field is 0, both slots are empty, and both stamp word pairs read 0.
- R2: Transmit control (offset 0x14): bit 4 is the read/write enable, bit 0 is the read-only slot-full flag, and all other bits read 0. Receive control (offset 0x20): bits 3:1 are a read/write type field, bit 4 is the read/write enable, bit 0 is the read-only slot-full flag, and bit 5 reads the `sysclk_fast` input. Writes never change the read-only bits.
- R3: A receive event is accepted when the slot is empty, receive enable is 1 and the type field is 3'b100 (control value 0x18). An accepted event raises `rx_stamped` in the same cycle. It stores the `sys_time` value of that cycle, and the slot-full flag reads 1 from the next cycle.
- R4: A receive event with enable 0, or with any type code other than 3'b100, leaves `rx_stamped` low and the slot empty.
- R5: While the receive slot is full, further receive events leave `rx_stamped` low and the held stamp unchanged.
- R6: A transmit event is accepted only when `tx_req` is 1, transmit enable is 1 and the slot is empty. It stores that cycle's `sys_time`.
- R7: While the transmit slot is full, further requested transmit events leave the held stamp unchanged.
- R8: A read strobe on a high stamp word (0x1C transmit, 0x28 receive) returns bits 63:32 of the stamp. The strobe empties that slot from the next cycle, and the slot accepts a new event after that.
- R9: A read strobe on a low stamp word (0x18 transmit, 0x24 receive) returns bits 31:0 and changes no state.
- R10: Clearing an enable leaves an already held stamp and its slot-full flag intact.
- R11: The register offsets are 0x14, 0x18, 0x1C, 0x20, 0x24 and 0x28 as above. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational on reg_addr |
| sys_time | input | 2*DATA_W | Running system time |
| sysclk_fast | input | 1 | System clock frequency indication, shown in receive control bit 5 |
| rx_event | input | 1 | Receive frame reached the stamp point |
| rx_stamped | output | 1 | The frame of this cycle's rx_event was stamped |
| tx_event | input | 1 | Transmit frame reached the stamp point |
| tx_req | input | 1 | The transmit frame requests a stamp |

## Verification
`rx_stamped` and `reg_rdata` are combinational, so the bench samples them 1 ns after it drives inputs on the falling edge, inside the same cycle. A capture, a release or a control write takes effect at the next rising edge. The bench therefore reads back the slot-full flags and stamps only from the following falling edge onward. Right after each event cycle it also drives `sys_time` to the complement of the event value, so a capture taken one cycle late would show up as a wrong stamp.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int unsigned TX_CTRL_OFS = 'h14;
    localparam int unsigned TX_LO_OFS   = 'h18;
    localparam int unsigned TX_HI_OFS   = 'h1C;
    localparam int unsigned RX_CTRL_OFS = 'h20;
    localparam int unsigned RX_LO_OFS   = 'h24;
    localparam int unsigned RX_HI_OFS   = 'h28;

    localparam int unsigned FULL_BIT = 0;
    localparam int unsigned TYPE_LSB = 1;
    localparam int unsigned TYPE_W   = 3;
    localparam int unsigned EN_BIT   = 4;
    localparam int unsigned FREQ_BIT = 5;

    localparam logic [TYPE_W-1:0] TYPE_EVERY = 3'b100;

    typedef struct packed {
        logic              tx_en;
        logic              rx_en;
        logic [TYPE_W-1:0] rx_type;
    } tsc_ctrl_t;
endpackage

// File: rtl/tsc_ctrl_regs.sv
module tsc_ctrl_regs
    import tsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output tsc_ctrl_t         ctrl_o
);
    tsc_ctrl_t ctrl_d, ctrl_q;
    logic      unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i && addr_i == ADDR_W'(TX_CTRL_OFS)) begin
            ctrl_d.tx_en = wdata_i[EN_BIT];
        end
        if (wr_i && addr_i == ADDR_W'(RX_CTRL_OFS)) begin
            ctrl_d.rx_en   = wdata_i[EN_BIT];
            ctrl_d.rx_type = wdata_i[TYPE_LSB +: TYPE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tsc_stamp_slot.sv
module tsc_stamp_slot #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_i,
    input  logic            event_i,
    input  logic [TS_W-1:0] time_i,
    input  logic            release_i,
    output logic            full_o,
    output logic [TS_W-1:0] stamp_o,
    output logic            taken_o
);
    typedef struct packed {
        logic            full;
        logic [TS_W-1:0] stamp;
    } slot_t;

    slot_t slot_d, slot_q;

    assign taken_o = event_i && arm_i && !slot_q.full;

    always_comb begin
        slot_d = slot_q;
        if (taken_o) begin
            slot_d.full  = 1'b1;
            slot_d.stamp = time_i;
        end else if (release_i) begin
            slot_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign full_o  = slot_q.full;
    assign stamp_o = slot_q.stamp;
endmodule

// File: rtl/pkt_tstamp_capture.sv
module pkt_tstamp_capture
    import tsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [2*DATA_W-1:0] sys_time,
    input  logic                sysclk_fast,
    input  logic                rx_event,
    output logic                rx_stamped,
    input  logic                tx_event,
    input  logic                tx_req
);
    localparam int TS_W = 2 * DATA_W;

    tsc_ctrl_t        ctrl;
    logic             tx_valid, rx_valid;
    logic [TS_W-1:0]  tx_stamp, rx_stamp;
    logic             tx_release, rx_release;
    logic             tx_taken;
    logic             unused_tx_taken;

    assign tx_release      = reg_rd && reg_addr == ADDR_W'(TX_HI_OFS);
    assign rx_release      = reg_rd && reg_addr == ADDR_W'(RX_HI_OFS);
    assign unused_tx_taken = tx_taken;

    tsc_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .ctrl_o  (ctrl)
    );

    tsc_stamp_slot #(.TS_W(TS_W)) u_tx_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (ctrl.tx_en && tx_req),
        .event_i   (tx_event),
        .time_i    (sys_time),
        .release_i (tx_release),
        .full_o    (tx_valid),
        .stamp_o   (tx_stamp),
        .taken_o   (tx_taken)
    );

    tsc_stamp_slot #(.TS_W(TS_W)) u_rx_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (ctrl.rx_en && ctrl.rx_type == TYPE_EVERY),
        .event_i   (rx_event),
        .time_i    (sys_time),
        .release_i (rx_release),
        .full_o    (rx_valid),
        .stamp_o   (rx_stamp),
        .taken_o   (rx_stamped)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(TX_CTRL_OFS): begin
                reg_rdata[FULL_BIT] = tx_valid;
                reg_rdata[EN_BIT]   = ctrl.tx_en;
            end
            ADDR_W'(TX_LO_OFS): reg_rdata = tx_stamp[DATA_W-1:0];
            ADDR_W'(TX_HI_OFS): reg_rdata = tx_stamp[TS_W-1:DATA_W];
            ADDR_W'(RX_CTRL_OFS): begin
                reg_rdata[FULL_BIT]              = rx_valid;
                reg_rdata[TYPE_LSB +: TYPE_W]    = ctrl.rx_type;
                reg_rdata[EN_BIT]                = ctrl.rx_en;
                reg_rdata[FREQ_BIT]              = sysclk_fast;
            end
            ADDR_W'(RX_LO_OFS): reg_rdata = rx_stamp[DATA_W-1:0];
            ADDR_W'(RX_HI_OFS): reg_rdata = rx_stamp[TS_W-1:DATA_W];
            default:            reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsc_capture_checker.sv
module tsc_capture_checker
    import tsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_rd,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [2*DATA_W-1:0] sys_time,
    input logic                rx_stamped,
    input logic                tx_event,
    input logic                tx_req,
    input logic                rx_valid,
    input logic                tx_valid,
    input logic [2*DATA_W-1:0] rx_stamp,
    input logic [2*DATA_W-1:0] tx_stamp
);
    logic rd_tx_hi, rd_rx_hi;
    assign rd_tx_hi = reg_rd && reg_addr == ADDR_W'(TX_HI_OFS);
    assign rd_rx_hi = reg_rd && reg_addr == ADDR_W'(RX_HI_OFS);

    a_r3_capture_time: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stamped |=> (rx_valid && rx_stamp == $past(sys_time)));

    a_r5_no_second_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !rx_stamped);

    a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_rx_hi) |=> (rx_valid && $stable(rx_stamp)));

    a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !rd_tx_hi) |=> (tx_valid && $stable(tx_stamp)));

    a_r6_tx_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !(tx_event && tx_req)) |=> !tx_valid);

    a_r8_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
        rd_tx_hi |=> !tx_valid);

    a_r8_rx_release: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rx_hi |=> !rx_valid);
endmodule

bind pkt_tstamp_capture tsc_capture_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .sys_time   (sys_time),
    .rx_stamped (rx_stamped),
    .tx_event   (tx_event),
    .tx_req     (tx_req),
    .rx_valid   (rx_valid),
    .tx_valid   (tx_valid),
    .rx_stamp   (rx_stamp),
    .tx_stamp   (tx_stamp)
);

// File: tb/pkt_tstamp_capture_test.sv
module pkt_tstamp_capture_test;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0, reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [63:0]       sys_time = '0;
    logic              sysclk_fast = 1'b1;
    logic              rx_event = 1'b0, tx_event = 1'b0, tx_req = 1'b0;
    logic              rx_stamped;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pkt_tstamp_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_time(sys_time), .sysclk_fast(sysclk_fast),
        .rx_event(rx_event), .rx_stamped(rx_stamped),
        .tx_event(tx_event), .tx_req(tx_req)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, {32'd0, d}, {32'd0, exp});
    endtask

    task automatic rx_pulse(input string tag, input logic [63:0] t, input logic exp_taken);
        @(negedge clk);
        rx_event = 1'b1; sys_time = t;
        #1 chk(tag, {63'd0, rx_stamped}, {63'd0, exp_taken});
        @(negedge clk);
        rx_event = 1'b0; sys_time = ~t;
    endtask

    task automatic tx_pulse(input logic [63:0] t, input logic req);
        @(negedge clk);
        tx_event = 1'b1; tx_req = req; sys_time = t;
        @(negedge clk);
        tx_event = 1'b0; tx_req = 1'b0; sys_time = ~t;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] t, t1, t2;
        logic        exp;
        int          k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R11: reset values and offsets
        rd_chk("R1 tx ctrl", 8'h14, 32'h0);
        rd_chk("R1 tx lo",   8'h18, 32'h0);
        rd_chk("R1 tx hi",   8'h1C, 32'h0);
        rd_chk("R1 rx ctrl", 8'h20, 32'h20);
        rd_chk("R1 rx lo",   8'h24, 32'h0);
        rd_chk("R1 rx hi",   8'h28, 32'h0);
        rd_chk("R11 unmapped 0x00", 8'h00, 32'h0);
        rd_chk("R11 unmapped 0x2C", 8'h2C, 32'h0);

        // R2: writable and read-only bits
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R2 tx ctrl all ones", 8'h14, 32'h10);
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk("R2 rx ctrl all ones", 8'h20, 32'h3E);
        sysclk_fast = 1'b0;
        rd_chk("R2 rx freq bit", 8'h20, 32'h1E);
        wr(8'h14, 32'h0);
        wr(8'h20, 32'h0);
        rd_chk("R2 tx ctrl cleared", 8'h14, 32'h0);
        rd_chk("R2 rx ctrl cleared", 8'h20, 32'h0);

        // R3 / R4 / R8: receive sweep over enable and type code
        k = 0;
        for (int en = 0; en < 2; en++) begin
            for (int ty = 0; ty < 8; ty++) begin
                t = 64'h0102_0304_0000_0000 + 64'(k) * 64'h0001_0001_0001_0011;
                wr(8'h20, 32'((en << 4) | (ty << 1)));
                exp = (en == 1) && (ty == 4);
                rx_pulse(exp ? "R3 rx_stamped" : "R4 rx_stamped", t, exp);
                rd_chk(exp ? "R3 rx full" : "R4 rx empty", 8'h20,
                       32'((en << 4) | (ty << 1)) | {31'd0, exp});
                if (exp) begin
                    rd_chk("R3 rx lo", 8'h24, t[31:0]);
                    rd_chk("R8 rx hi", 8'h28, t[63:32]);
                    rd_chk("R8 rx released", 8'h20, 32'h18);
                end
                k++;
            end
        end

        // R6: transmit sweep over enable and request
        for (int en = 0; en < 2; en++) begin
            for (int rq = 0; rq < 2; rq++) begin
                t = 64'hA5A5_0000_5A5A_0000 + 64'(k) * 64'h0000_0101_0000_0707;
                wr(8'h14, 32'(en << 4));
                tx_pulse(t, rq[0]);
                exp = (en == 1) && (rq == 1);
                rd_chk("R6 tx full flag", 8'h14, 32'(en << 4) | {31'd0, exp});
                if (exp) begin
                    rd_chk("R6 tx lo", 8'h18, t[31:0]);
                    rd_chk("R8 tx hi", 8'h1C, t[63:32]);
                    rd_chk("R8 tx released", 8'h14, 32'h10);
                end
                k++;
            end
        end

        // R5 / R9 / R10: receive lock, low reads and enable clear
        t1 = 64'h1111_2222_3333_4444;
        t2 = 64'h5555_6666_7777_8888;
        wr(8'h20, 32'h18);
        rx_pulse("R3 lock first", t1, 1'b1);
        rx_pulse("R5 second refused", t2, 1'b0);
        rd_chk("R5 rx lo held", 8'h24, t1[31:0]);
        rd_chk("R9 rx lo again", 8'h24, t1[31:0]);
        rd_chk("R9 rx still full", 8'h20, 32'h19);
        wr(8'h20, 32'h0);
        rd_chk("R10 full after disable", 8'h20, 32'h01);
        rd_chk("R10 rx hi held", 8'h28, t1[63:32]);
        rd_chk("R8 rx empty", 8'h20, 32'h0);
        wr(8'h20, 32'h18);
        rx_pulse("R8 rearmed", t2, 1'b1);
        rd_chk("R8 rx new lo", 8'h24, t2[31:0]);
        rd_chk("R8 rx new hi", 8'h28, t2[63:32]);

        // R7 / R9 / R10: transmit lock
        wr(8'h14, 32'h10);
        tx_pulse(t2, 1'b1);
        tx_pulse(t1, 1'b1);
        rd_chk("R7 tx lo held", 8'h18, t2[31:0]);
        rd_chk("R9 tx still full", 8'h14, 32'h11);
        wr(8'h14, 32'h0);
        rd_chk("R10 tx full after disable", 8'h14, 32'h01);
        rd_chk("R7 tx hi held", 8'h1C, t2[63:32]);
        rd_chk("R8 tx empty", 8'h14, 32'h0);

        summary();
    end
endmodule